// File: doc/BRIEF.md
# Region-Atomic Persist Staging Buffer

This block sits inside a memory controller on a write path that bypasses the caches. The core sends it stores, which may hold register checkpoint values as well as ordinary data. It also sends boundary tokens, and each token closes the current group of stores, called a region. Stores of the open region are only held in a small buffer. Each store keeps its own entry in arrival order, and the block does not merge stores across regions. A store that hits an address already held in the open region replaces that entry's data.

Once a region is closed, a drain engine moves its entries to main memory one at a time, oldest first. Each entry takes three steps:
1. Read the old value at the entry's address.
2. Record the address and old value in an internal undo log.
3. Write the new value.

After the last entry of a region is written, the undo log is cleared and a one-cycle completion pulse is raised. The core may keep sending stores for the next region while an earlier region drains.

When the recovery input is pulsed, the block stops draining. It writes the logged old values back to memory, newest first, so a half-written region is undone. It then throws away every store of the region that was never closed. Closed regions stay in the buffer and are drained again from their first entry.

Top module: `persist_stage`

## Requirements
- R1: After reset, stReady and bndReady are 1, memEn is 0 and regionDone is 0.
- R2: A store of a region whose boundary has not been accepted causes no memory access and does not change memory.
- R3: Each staged entry is drained in three steps. First comes a read at its address (memEn=1, memWe=0), with the old data returned on memRdata in the next cycle. Then comes one cycle with no memory access. Then comes a write of the entry's data to that address (memEn=1, memWe=1) exactly two cycles after the read. Entries drain in arrival order, and stores to the same address in different regions are each written.
- R4: A store to an address already staged in the still-open region replaces that entry's data and takes no new entry. The address is then drained once, with the newest data, at the position of its first store.
- R5: regionDone is high for exactly one cycle, the cycle right after the final write of a region. It pulses once per region that holds at least one store.
- R6: While a region drains and the buffer has free entries, stReady stays 1, so stores of the next region are accepted without delay.
- R7: With DEPTH (16) entries held, stReady is 0. While a drain is in progress and the buffer is full, bndReady is 0.
- R8: A recover pulse ends any drain step in that cycle. The block then writes the logged old values back to their addresses, newest first, and discards all stores of the open region, which are never written. After that it drains the closed regions again from their first entry. stReady is 0 while the recovery runs.
- R9: A boundary accepted while no store is staged in the open region causes no memory access and no regionDone pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | A store is offered |
| stReady | output | 1 | Store is accepted in a cycle where stValid and stReady are both 1 |
| stAddr | input | ADDR_W | Store address |
| stData | input | DATA_W | Store data |
| bndValid | input | 1 | A region boundary token is offered |
| bndReady | output | 1 | Boundary is accepted in a cycle where bndValid and bndReady are both 1 |
| recover | input | 1 | One-cycle recovery request |
| memEn | output | 1 | Memory access in this cycle |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Memory address |
| memWdata | output | DATA_W | Memory write data |
| memRdata | input | DATA_W | Read data, valid the cycle after a read request |
| regionDone | output | 1 | One-cycle pulse when a region is fully in memory |

## Verification
A bad buffer pointer or a bad closing mark shows up on the memory port within a few cycles of the next boundary. The symptoms are a write to the wrong address, a write that comes too early, a read or write that is missing, or a regionDone pulse at the wrong time. A bad undo-log count shows up only during recovery, as a missing restore write or a restore in the wrong order. Staging faults, such as an open store leaking out or a merge that did not happen, show up as an extra access or wrong data once the region drains. The scoreboard compares every memory access against a queue computed from the store stream, and it checks the spacing from each read to its write.

// File: rtl/persist_stage_pkg.sv
package persist_stage_pkg;

  typedef enum logic [2:0] {
    DR_IDLE,
    DR_READ,
    DR_LOG,
    DR_WRITE,
    DR_RECOVER
  } drainState_t;

  typedef struct packed {
    logic push;       // store accepted this cycle
    logic close;      // boundary accepted this cycle
    logic memRd;      // read old value of drain entry
    logic logWr;      // capture old value into undo log
    logic memWr;      // write new value of drain entry
    logic advance;    // step to next entry of same region
    logic retire;     // last entry of region done
    logic replay;     // restore newest undo log entry
    logic recFinish;  // drop open stores, rewind drain
  } ctrlStrobe_t;

endpackage

// File: rtl/persist_stage_ctl.sv
module persist_stage_ctl
  import persist_stage_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stValid,
  input  logic        bndValid,
  input  logic        recover,
  input  logic        full,
  input  logic        drainAvail,
  input  logic        drainLast,
  input  logic        nextAvail,
  input  logic        logEmpty,
  output logic        stReady,
  output logic        bndReady,
  output logic        regionDone,
  output ctrlStrobe_t s
);

  drainState_t state, nextState;

  always_comb begin
    stReady   = (state != DR_RECOVER) && !full;
    bndReady  = (state != DR_RECOVER) && !((state != DR_IDLE) && full);
    s         = '0;
    s.push    = stValid && stReady;
    s.close   = bndValid && bndReady;
    nextState = state;
    if (recover && state != DR_RECOVER) begin
      nextState = DR_RECOVER;
    end else begin
      case (state)
        DR_IDLE:  if (drainAvail) nextState = DR_READ;
        DR_READ: begin
          s.memRd   = 1'b1;
          nextState = DR_LOG;
        end
        DR_LOG: begin
          s.logWr   = 1'b1;
          nextState = DR_WRITE;
        end
        DR_WRITE: begin
          s.memWr = 1'b1;
          if (drainLast) s.retire = 1'b1;
          else           s.advance = 1'b1;
          nextState = nextAvail ? DR_READ : DR_IDLE;
        end
        DR_RECOVER: begin
          if (!logEmpty) begin
            s.replay = 1'b1;
          end else begin
            s.recFinish = 1'b1;
            nextState   = DR_IDLE;
          end
        end
        default: nextState = DR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= DR_IDLE;
      regionDone <= 1'b0;
    end else begin
      state      <= nextState;
      regionDone <= s.retire;
    end
  end

  // R3: a new value is written only right after its old value was logged
  assert_log_before_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    s.memWr |-> $past(s.logWr));

  // R5: completion pulse follows a memory write
  assert_done_after_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    regionDone |-> $past(s.memWr));

  // R8: no drain step runs during recovery
  assert_rec_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == DR_RECOVER) |-> !(s.memRd || s.logWr || s.memWr));

endmodule

// File: rtl/persist_stage_dp.sv
module persist_stage_dp
  import persist_stage_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       s,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [DATA_W-1:0] memRdata,
  output logic              full,
  output logic              drainAvail,
  output logic              drainLast,
  output logic              nextAvail,
  output logic              logEmpty,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);

  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] ONE = (PW+1)'(1);
  localparam logic [PW:0] CAP = (PW+1)'(DEPTH);

  logic [ADDR_W-1:0] entAddr   [DEPTH];
  logic [DATA_W-1:0] entData   [DEPTH];
  logic              entClosed [DEPTH];
  logic              entLast   [DEPTH];
  logic [ADDR_W-1:0] logAddr   [DEPTH];
  logic [DATA_W-1:0] logData   [DEPTH];

  logic [PW:0] head, tail, drainPtr, openCnt, logCnt;
  logic [PW:0] count, drainNext;
  logic [PW-1:0] tIdx, tPrev, dIdx, nIdx, lIdx, lTop;
  logic [DEPTH-1:0] hitVec;
  logic hitAny, append;
  logic [PW-1:0] hitIdx;

  always_comb begin
    count     = tail - head;
    full      = (count == CAP);
    tIdx      = tail[PW-1:0];
    tPrev     = tIdx - PW'(1);
    dIdx      = drainPtr[PW-1:0];
    nIdx      = dIdx + PW'(1);
    drainNext = drainPtr + ONE;
    lIdx      = logCnt[PW-1:0];
    lTop      = lIdx - PW'(1);
    logEmpty  = (logCnt == '0);
    hitIdx    = '0;
    for (int i = 0; i < DEPTH; i++) begin
      logic [PW-1:0] off;
      off       = PW'(i) - head[PW-1:0];
      hitVec[i] = ({1'b0, off} < count) && !entClosed[i] && (entAddr[i] == stAddr);
      if (hitVec[i]) hitIdx = PW'(i);
    end
    hitAny     = |hitVec;
    append     = s.push && !hitAny;
    drainAvail = (drainPtr != tail) && entClosed[dIdx];
    drainLast  = entLast[dIdx];
    nextAvail  = (drainNext != tail) && entClosed[nIdx];
    memEn      = s.memRd || s.memWr || s.replay;
    memWe      = s.memWr || s.replay;
    memAddr    = s.replay ? logAddr[lTop] : entAddr[dIdx];
    memWdata   = s.replay ? logData[lTop] : entData[dIdx];
  end

  // entry and log storage
  always_ff @(posedge clk) begin
    if (s.close) begin
      for (int i = 0; i < DEPTH; i++) entClosed[i] <= 1'b1;
      if (!append && openCnt != '0) entLast[tPrev] <= 1'b1;
    end
    if (s.push) begin
      if (hitAny) begin
        entData[hitIdx] <= stData;
      end else begin
        entAddr[tIdx]   <= stAddr;
        entData[tIdx]   <= stData;
        entClosed[tIdx] <= s.close;
        entLast[tIdx]   <= s.close;
      end
    end
    if (s.logWr) begin
      logAddr[lIdx] <= entAddr[dIdx];
      logData[lIdx] <= memRdata;
    end
  end

  // pointers and counts
  always_ff @(posedge clk) begin
    if (!rstN) begin
      head     <= '0;
      tail     <= '0;
      drainPtr <= '0;
      openCnt  <= '0;
      logCnt   <= '0;
    end else begin
      if (append) tail <= tail + ONE;
      if (s.close)     openCnt <= '0;
      else if (append) openCnt <= openCnt + ONE;
      if (s.logWr)   logCnt   <= logCnt + ONE;
      if (s.advance) drainPtr <= drainNext;
      if (s.retire) begin
        head     <= drainNext;
        drainPtr <= drainNext;
        logCnt   <= '0;
      end
      if (s.replay) logCnt <= logCnt - ONE;
      if (s.recFinish) begin
        tail     <= tail - openCnt;
        openCnt  <= '0;
        drainPtr <= head;
      end
    end
  end

  // R7: a new entry is never taken while all entries are in use
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    append |-> (count < CAP));

  // R2: only entries of closed regions reach memory
  assert_drain_closed_R2: assert property (@(posedge clk) disable iff (!rstN)
    s.memWr |-> drainAvail);

  // R8: restore writes only come from a non-empty undo log
  assert_replay_nonempty_R8: assert property (@(posedge clk) disable iff (!rstN)
    s.replay |-> (logCnt != '0));

  // R8: undo log never holds more than one region's worth of entries
  assert_log_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    logCnt <= CAP);

endmodule

// File: rtl/persist_stage.sv
module persist_stage
  import persist_stage_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stValid,
  output logic              stReady,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic              bndValid,
  output logic              bndReady,
  input  logic              recover,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              regionDone
);

  ctrlStrobe_t strobe;
  logic full, drainAvail, drainLast, nextAvail, logEmpty;

  persist_stage_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .stValid    (stValid),
    .bndValid   (bndValid),
    .recover    (recover),
    .full       (full),
    .drainAvail (drainAvail),
    .drainLast  (drainLast),
    .nextAvail  (nextAvail),
    .logEmpty   (logEmpty),
    .stReady    (stReady),
    .bndReady   (bndReady),
    .regionDone (regionDone),
    .s          (strobe)
  );

  persist_stage_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .s          (strobe),
    .stAddr     (stAddr),
    .stData     (stData),
    .memRdata   (memRdata),
    .full       (full),
    .drainAvail (drainAvail),
    .drainLast  (drainLast),
    .nextAvail  (nextAvail),
    .logEmpty   (logEmpty),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memWdata   (memWdata)
  );

endmodule

// File: tb/sim_persist_stage.sv
module sim_persist_stage;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic stValid = 1'b0, bndValid = 1'b0, recover = 1'b0;
  logic stReady, bndReady, memEn, memWe, regionDone;
  logic [AW-1:0] stAddr = '0, memAddr;
  logic [DW-1:0] stData = '0, memWdata, memRdata;

  persist_stage #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .bndValid(bndValid), .bndReady(bndReady),
    .recover(recover), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .regionDone(regionDone)
  );

  // main memory model, preloaded with 0xA000 + address
  logic [DW-1:0] mem [256];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= DW'(16'hA000 + i);
      memRdata <= '0;
    end else if (memEn) begin
      if (memWe) mem[memAddr] <= memWdata;
      else       memRdata <= mem[memAddr];
    end
  end

  typedef struct {
    bit we; logic [AW-1:0] addr; logic [DW-1:0] data; bit drain; bit lastOf; string req;
  } item_t;
  item_t expQ[$];
  logic [AW-1:0] openA[$];
  logic [DW-1:0] openD[$];

  int checks = 0, errors = 0, doneCnt = 0, expDone = 0, cyc = 0, lastRd = 0;
  bit pendDone = 1'b0, finished = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic addItem(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit drain, input bit lastOf, input string req);
    item_t e;
    e.we = we; e.addr = a; e.data = d; e.drain = drain; e.lastOf = lastOf; e.req = req;
    expQ.push_back(e);
  endtask

  // called at a negedge, returns at a negedge; R4 model merges open-region stores
  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bit found = 1'b0;
    foreach (openA[i]) if (openA[i] == a) begin openD[i] = d; found = 1'b1; end
    if (!found) begin openA.push_back(a); openD.push_back(d); end
    stAddr = a; stData = d; stValid = 1'b1;
    while (!stReady) @(negedge clk);
    @(negedge clk);
    stValid = 1'b0;
  endtask

  task automatic boundary(input string req);
    foreach (openA[i]) begin
      addItem(1'b0, openA[i], '0, 1'b1, 1'b0, req);
      addItem(1'b1, openA[i], openD[i], 1'b1, i == openA.size() - 1, req);
    end
    if (openA.size() != 0) expDone++;
    openA.delete(); openD.delete();
    bndValid = 1'b1;
    while (!bndReady) @(negedge clk);
    @(negedge clk);
    bndValid = 1'b0;
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !finished) begin
      cyc++;
      if (pendDone) begin
        chk(regionDone == 1'b1, "R5", regionDone, 1);
        pendDone = 1'b0;
      end
      if (regionDone) doneCnt++;
      if (memEn) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R2", {memWe, memAddr, memWdata}, 0);
        end else begin
          item_t e;
          e = expQ.pop_front();
          chk(memWe == e.we && memAddr == e.addr && (!e.we || memWdata == e.data), e.req,
              {memWe, memAddr, memWdata}, {e.we, e.addr, e.data});
          if (e.drain && !e.we) lastRd = cyc;
          if (e.drain && e.we) chk(cyc - lastRd == 2, "R3", cyc - lastRd, 2);
          if (e.lastOf) pendDone = 1'b1;
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(stReady == 1'b1, "R1", stReady, 1);
    chk(bndReady == 1'b1, "R1", bndReady, 1);
    chk(memEn == 1'b0, "R1", memEn, 0);
    chk(regionDone == 1'b0, "R1", regionDone, 0);

    // R2 staging holds stores; R3 drain after the boundary
    push(8'h01, 16'h0011); push(8'h02, 16'h0022); push(8'h03, 16'h0033);
    repeat (10) @(negedge clk);
    chk(mem[1] == 16'hA001, "R2", mem[1], 16'hA001);
    chk(doneCnt == 0, "R2", doneCnt, 0);
    boundary("R3");
    waitDrain();
    chk(mem[3] == 16'h0033, "R3", mem[3], 16'h0033);
    chk(doneCnt == expDone, "R5", doneCnt, expDone);

    // R4 merging in the open region
    push(8'h05, 16'h0001); push(8'h06, 16'h0002); push(8'h05, 16'h0003);
    boundary("R4");
    waitDrain();
    chk(mem[5] == 16'h0003, "R4", mem[5], 16'h0003);

    // R3 same address in two regions is written twice
    push(8'h07, 16'h0004); boundary("R3");
    push(8'h07, 16'h0005); boundary("R3");
    waitDrain();
    chk(mem[7] == 16'h0005, "R3", mem[7], 16'h0005);

    // R6 next region accepted while the previous drains
    for (int i = 0; i < 4; i++) push(AW'(8'h30 + i), DW'(16'h0300 + i));
    boundary("R6");
    for (int i = 0; i < 3; i++) begin
      chk(stReady == 1'b1, "R6", stReady, 1);
      push(AW'(8'h38 + i), DW'(16'h0380 + i));
    end
    boundary("R6");
    waitDrain();
    chk(mem[8'h3A] == 16'h0382, "R6", mem[8'h3A], 16'h0382);
    chk(doneCnt == expDone, "R5", doneCnt, expDone);

    // R9 empty region
    d = doneCnt;
    boundary("R9");
    repeat (20) @(negedge clk);
    chk(doneCnt == d, "R9", doneCnt, d);

    // R7 full buffer
    for (int i = 0; i < DEPTH; i++) push(AW'(8'h40 + i), DW'(16'h0100 + i));
    chk(stReady == 1'b0, "R7", stReady, 0);
    chk(bndReady == 1'b1, "R7", bndReady, 1);
    boundary("R7");
    @(negedge clk);
    chk(bndReady == 1'b0, "R7", bndReady, 0);
    chk(stReady == 1'b0, "R7", stReady, 0);
    waitDrain();
    chk(stReady == 1'b1 && bndReady == 1'b1, "R7", {stReady, bndReady}, 2'b11);

    // R8 recovery in the middle of a region
    push(8'h10, 16'h0001); push(8'h11, 16'h0002); push(8'h12, 16'h0003);
    boundary("R8");
    push(8'h20, 16'h0009);
    while (!(memEn && !memWe && memAddr == 8'h12)) @(negedge clk);
    @(negedge clk);
    recover = 1'b1;
    expQ.delete(); openA.delete(); openD.delete();
    addItem(1'b1, 8'h11, 16'hA011, 1'b0, 1'b0, "R8");
    addItem(1'b1, 8'h10, 16'hA010, 1'b0, 1'b0, "R8");
    addItem(1'b0, 8'h10, '0, 1'b1, 1'b0, "R8");
    addItem(1'b1, 8'h10, 16'h0001, 1'b1, 1'b0, "R8");
    addItem(1'b0, 8'h11, '0, 1'b1, 1'b0, "R8");
    addItem(1'b1, 8'h11, 16'h0002, 1'b1, 1'b0, "R8");
    addItem(1'b0, 8'h12, '0, 1'b1, 1'b0, "R8");
    addItem(1'b1, 8'h12, 16'h0003, 1'b1, 1'b1, "R8");
    @(negedge clk);
    recover = 1'b0;
    chk(stReady == 1'b0, "R8", stReady, 0);
    waitDrain();
    chk(mem[8'h10] == 16'h0001, "R8", mem[8'h10], 16'h0001);
    chk(mem[8'h12] == 16'h0003, "R8", mem[8'h12], 16'h0003);
    chk(mem[8'h20] == 16'hA020, "R8", mem[8'h20], 16'hA020);
    boundary("R8");
    repeat (20) @(negedge clk);
    chk(mem[8'h20] == 16'hA020, "R8", mem[8'h20], 16'hA020);
    chk(doneCnt == expDone, "R5", doneCnt, expDone);
    chk(expQ.size() == 0, "R3", expQ.size(), 0);
    finishRun();
  end

endmodule